// File: doc/BRIEF.md
# ATA PIO Sector Command Engine

This block sits behind a host-facing register file for a PIO disk interface. The host loads the sector count, a 28-bit logical block address and a command byte. The engine then runs the command. It raises and drops the busy and data-request flags and moves sector data through an internal one-sector buffer. It raises an interrupt line at the points the protocol calls for.

Sector data reaches the storage medium through a word-wide request/acknowledge port. The engine holds a request with a fixed address and word index until the medium acknowledges it. On a read, the returned word is captured into the buffer. On a write, the buffered word is driven out.

The engine supports the following commands:
- single-sector and block-grouped reads and writes
- read verify, which reads the medium but never asks the host for a transfer
- setting the block size
- seek, which only checks the address range
- no-operation commands: recalibrate and the power-state commands

Any other opcode is aborted.

Top module: `ata_cmd_engine`

## Requirements
- R1: After reset the status byte reads 50h (ready, seek complete), the error byte reads 00h and the interrupt line is low.
- R2: Opcodes 1xh, E0h-E3h, E6h and 94h-97h, 99h complete with status 50h and an interrupt. Seek (7xh) does the same when the address is in range. Any opcode outside the supported set ends with error byte 04h (abort), status 51h and an interrupt.
- R3: A sector count of 0 transfers 256 sectors; 1 to 255 transfer that many.
- R4: Each sector of a read is fetched from the medium into the buffer and then offered with status 58h. The host reads WORDS data-register words (default 256) in medium order. In single-sector mode the interrupt rises when each sector's data request starts. A read does not interrupt at its end.
- R5: On a write the first data request (status 58h) comes without an interrupt. After the last word of a sector the data request drops and status reads 80h while the buffer is written to the medium. The next data request raises the interrupt. The end of the command raises it too, with status 50h.
- R6: Opcodes C4h and C5h group sectors in blocks of the programmed size. A read interrupts only at the first sector of each block. A write interrupts after each full block and at the end.
- R7: Opcode C6h accepts a block size of 1 to MAX_MULT from the sector count register. Any other value is aborted. C4h or C5h issued before a valid block size is set is also aborted.
- R8: Read verify (40h, 41h) reads every sector from the medium but never sets the data-request flag. It ends with status 50h and an interrupt.
- R9: The address advances by one after each sector, and the address registers read back the next address when the command ends.
- R10: Starting a sector at an address at or above CAP_SECTORS ends the command with error byte 10h, status 51h and an interrupt. Seek applies the same check.
- R11: While busy (status 80h) every register write from the host is ignored, including a new command.
- R12: Reading status at address 7 clears the interrupt. Reading status through the control-block select does not clear it.
- R13: Accepting a new command clears the error byte and the error status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe, one cycle |
| host_rd | input | 1 | Host register read strobe, one cycle |
| ctl_blk | input | 1 | Select control block: reads return status without side effect |
| host_addr | input | 3 | Register select: 0 data, 1 error, 2 count, 3-5 address bytes, 6 device/high address, 7 status/command |
| host_wdata | input | 16 | Write data (registers use bits 7:0) |
| host_rdata | output | 16 | Read data for the selected register |
| intrq | output | 1 | Interrupt request |
| med_req | output | 1 | Medium word request, held until acknowledged |
| med_we | output | 1 | Request direction: 1 writes to the medium |
| med_lba | output | 28 | Sector address of the request |
| med_widx | output | log2(WORDS) | Word index inside the sector |
| med_wdata | output | 16 | Word written to the medium |
| med_ack | input | 1 | One-cycle acknowledge from the medium |
| med_rdata | input | 16 | Word returned with the acknowledge on reads |

## Verification
The hardest situations to reach are a 256-sector transfer from a zero count and a command that crosses the capacity limit in its second sector. The bench drives read verify for both, so that no host data movement is needed and the runs stay short. It shrinks the sector to 16 words and puts the capacity limit one sector past the start address. A further hard case is a command written while the engine is busy. The bench issues it in the cycle after a verify starts, then shows at the ports that no data request ever appears and that the sector count register kept its value.

// File: rtl/ata_eng_pkg.sv
package ata_eng_pkg;

  typedef enum logic [2:0] {
    OP_READ, OP_WRITE, OP_VERIFY, OP_SETMULT, OP_NOP, OP_SEEK, OP_BAD
  } op_kind_t;

  typedef struct packed {
    op_kind_t kind;
    logic     multi;
  } op_dec_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_PREP, ST_FETCH, ST_XRD, ST_XWR, ST_COMMIT
  } eng_state_t;

  localparam logic [7:0] ERR_ABRT = 8'h04;
  localparam logic [7:0] ERR_IDNF = 8'h10;
  localparam logic [7:0] STAT_BSY = 8'h80;

endpackage

// File: rtl/ata_opc_decode.sv
module ata_opc_decode
  import ata_eng_pkg::*;
(
  input  logic [7:0] opc,
  output op_dec_t    dec
);
  always_comb begin
    dec.multi = 1'b0;
    dec.kind  = OP_BAD;
    if (opc[7:4] == 4'h1) begin
      dec.kind = OP_NOP;
    end else if (opc[7:4] == 4'h7) begin
      dec.kind = OP_SEEK;
    end else begin
      case (opc)
        8'h20, 8'h21: dec.kind = OP_READ;
        8'h30, 8'h31: dec.kind = OP_WRITE;
        8'h40, 8'h41: dec.kind = OP_VERIFY;
        8'hC4: begin dec.kind = OP_READ;  dec.multi = 1'b1; end
        8'hC5: begin dec.kind = OP_WRITE; dec.multi = 1'b1; end
        8'hC6: dec.kind = OP_SETMULT;
        8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6,
        8'h94, 8'h95, 8'h96, 8'h97, 8'h99: dec.kind = OP_NOP;
        default: dec.kind = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/ata_sect_buf.sv
module ata_sect_buf #(
  parameter int WORDS = 256,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ata_cmd_engine.sv
module ata_cmd_engine
  import ata_eng_pkg::*;
#(
  parameter int WORDS       = 256,
  parameter int CAP_SECTORS = 4096,
  parameter int MAX_MULT    = 16,
  localparam int WIDX_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              ctl_blk,
  input  logic [2:0]        host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              intrq,
  output logic              med_req,
  output logic              med_we,
  output logic [27:0]       med_lba,
  output logic [WIDX_W-1:0] med_widx,
  output logic [15:0]       med_wdata,
  input  logic              med_ack,
  input  logic [15:0]       med_rdata
);
  localparam int MULT_W = $clog2(MAX_MULT + 1);
  localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(WORDS - 1);
  localparam logic [27:0]       CAP_L    = 28'(CAP_SECTORS);
  localparam logic [7:0]        MAXM_L   = 8'(MAX_MULT);
  localparam logic [MULT_W-1:0] M_ONE    = MULT_W'(1);

  eng_state_t state_q, state_n;
  op_kind_t   kind_q, kind_n;
  logic [WIDX_W-1:0] ptr_q, ptr_n;
  logic [27:0] lba_q, lba_n;
  logic [3:0]  dev_q, dev_n;
  logic [7:0]  sc_q, sc_n, err_q, err_n, cmd_q, cmd_n;
  logic [8:0]  rem_q, rem_n;
  logic [MULT_W-1:0] blk_q, blk_n, bsz_q, bsz_n, mult_q, mult_n, bsz_c;
  logic errf_q, errf_n, intr_q, intr_n, req_q, req_n, first_q, first_n;

  logic        buf_we, sect_done, busy, drq, tf_wr, stat_rd, dat_rd, dat_wr;
  logic [15:0] buf_wd, buf_rd;
  logic [7:0]  stat;
  op_dec_t     dec;

  ata_opc_decode u_dec (.opc(cmd_q), .dec(dec));

  ata_sect_buf #(.WORDS(WORDS)) u_buf (
    .clk(clk), .we(buf_we), .addr(ptr_q), .wdata(buf_wd), .rdata(buf_rd)
  );

  assign drq     = (state_q == ST_XRD) || (state_q == ST_XWR);
  assign busy    = (state_q != ST_IDLE) && !drq;
  assign stat    = busy ? STAT_BSY : {4'b0101, drq, 2'b00, errf_q};
  assign tf_wr   = host_wr && !ctl_blk;
  assign stat_rd = host_rd && !ctl_blk && (host_addr == 3'd7);
  assign dat_rd  = host_rd && !ctl_blk && (host_addr == 3'd0) && (state_q == ST_XRD);
  assign dat_wr  = tf_wr && (host_addr == 3'd0) && (state_q == ST_XWR);
  assign bsz_c   = dec.multi ? mult_q : M_ONE;

  always_comb begin
    if (ctl_blk) host_rdata = {8'h00, stat};
    else begin
      case (host_addr)
        3'd0:    host_rdata = buf_rd;
        3'd1:    host_rdata = {8'h00, err_q};
        3'd2:    host_rdata = {8'h00, sc_q};
        3'd3:    host_rdata = {8'h00, lba_q[7:0]};
        3'd4:    host_rdata = {8'h00, lba_q[15:8]};
        3'd5:    host_rdata = {8'h00, lba_q[23:16]};
        3'd6:    host_rdata = {8'h00, dev_q, lba_q[27:24]};
        default: host_rdata = {8'h00, stat};
      endcase
    end
  end

  assign intrq     = intr_q;
  assign med_req   = req_q;
  assign med_we    = (state_q == ST_COMMIT);
  assign med_lba   = lba_q;
  assign med_widx  = ptr_q;
  assign med_wdata = buf_rd;

  always_comb begin
    state_n = state_q; kind_n = kind_q; ptr_n = ptr_q; lba_n = lba_q;
    dev_n = dev_q; sc_n = sc_q; err_n = err_q; cmd_n = cmd_q; rem_n = rem_q;
    blk_n = blk_q; bsz_n = bsz_q; mult_n = mult_q; errf_n = errf_q;
    intr_n = intr_q; req_n = req_q; first_n = first_q;
    buf_we = 1'b0; buf_wd = host_wdata; sect_done = 1'b0;
    if (stat_rd) intr_n = 1'b0;
    case (state_q)
      ST_IDLE: if (tf_wr) begin
        case (host_addr)
          3'd2: sc_n = host_wdata[7:0];
          3'd3: lba_n[7:0] = host_wdata[7:0];
          3'd4: lba_n[15:8] = host_wdata[7:0];
          3'd5: lba_n[23:16] = host_wdata[7:0];
          3'd6: begin dev_n = host_wdata[7:4]; lba_n[27:24] = host_wdata[3:0]; end
          3'd7: begin cmd_n = host_wdata[7:0]; err_n = '0; errf_n = 1'b0; state_n = ST_DECODE; end
          default: ;
        endcase
      end
      ST_DECODE: begin
        state_n = ST_IDLE;
        intr_n  = 1'b1;
        case (dec.kind)
          OP_READ, OP_WRITE, OP_VERIFY: begin
            if (dec.multi && (mult_q == '0)) begin
              err_n = ERR_ABRT; errf_n = 1'b1;
            end else begin
              intr_n  = intr_q && !stat_rd;
              state_n = ST_PREP;
              kind_n  = dec.kind;
              rem_n   = (sc_q == 8'd0) ? 9'd256 : {1'b0, sc_q};
              bsz_n   = bsz_c;
              blk_n   = (dec.kind == OP_WRITE) ? (bsz_c - M_ONE) : '0;
              first_n = 1'b1;
              ptr_n   = '0;
            end
          end
          OP_SETMULT: begin
            if ((sc_q != 8'd0) && (sc_q <= MAXM_L)) mult_n = MULT_W'(sc_q);
            else begin err_n = ERR_ABRT; errf_n = 1'b1; end
          end
          OP_NOP: ;
          OP_SEEK: if (lba_q >= CAP_L) begin err_n = ERR_IDNF; errf_n = 1'b1; end
          default: begin err_n = ERR_ABRT; errf_n = 1'b1; end
        endcase
      end
      ST_PREP: begin
        if (lba_q >= CAP_L) begin
          err_n = ERR_IDNF; errf_n = 1'b1; intr_n = 1'b1; state_n = ST_IDLE;
        end else if (kind_q == OP_WRITE) begin
          state_n = ST_XWR;
          first_n = 1'b0;
          if (!first_q) begin
            if (blk_q == '0) begin intr_n = 1'b1; blk_n = bsz_q - M_ONE; end
            else blk_n = blk_q - M_ONE;
          end
        end else begin
          state_n = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (!req_q) req_n = 1'b1;
        else if (med_ack) begin
          req_n = 1'b0; buf_we = 1'b1; buf_wd = med_rdata;
          if (ptr_q != LAST_IDX) ptr_n = ptr_q + WIDX_W'(1);
          else if (kind_q == OP_VERIFY) sect_done = 1'b1;
          else begin
            state_n = ST_XRD; ptr_n = '0;
            if (blk_q == '0) begin intr_n = 1'b1; blk_n = bsz_q - M_ONE; end
            else blk_n = blk_q - M_ONE;
          end
        end
      end
      ST_XRD: if (dat_rd) begin
        if (ptr_q == LAST_IDX) sect_done = 1'b1;
        else ptr_n = ptr_q + WIDX_W'(1);
      end
      ST_XWR: if (dat_wr) begin
        buf_we = 1'b1;
        if (ptr_q == LAST_IDX) begin state_n = ST_COMMIT; ptr_n = '0; end
        else ptr_n = ptr_q + WIDX_W'(1);
      end
      ST_COMMIT: begin
        if (!req_q) req_n = 1'b1;
        else if (med_ack) begin
          req_n = 1'b0;
          if (ptr_q == LAST_IDX) sect_done = 1'b1;
          else ptr_n = ptr_q + WIDX_W'(1);
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (sect_done) begin
      lba_n = lba_q + 28'd1;
      rem_n = rem_q - 9'd1;
      ptr_n = '0;
      if (rem_q == 9'd1) begin
        state_n = ST_IDLE;
        if (kind_q != OP_READ) intr_n = 1'b1;
      end else begin
        state_n = ST_PREP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; kind_q <= OP_NOP; ptr_q <= '0; lba_q <= '0;
      dev_q <= '0; sc_q <= '0; err_q <= '0; cmd_q <= '0; rem_q <= '0;
      blk_q <= '0; bsz_q <= '0; mult_q <= '0; errf_q <= 1'b0;
      intr_q <= 1'b0; req_q <= 1'b0; first_q <= 1'b0;
    end else begin
      state_q <= state_n; kind_q <= kind_n; ptr_q <= ptr_n; lba_q <= lba_n;
      dev_q <= dev_n; sc_q <= sc_n; err_q <= err_n; cmd_q <= cmd_n; rem_q <= rem_n;
      blk_q <= blk_n; bsz_q <= bsz_n; mult_q <= mult_n; errf_q <= errf_n;
      intr_q <= intr_n; req_q <= req_n; first_q <= first_n;
    end
  end
endmodule

// File: rtl/ata_cmd_engine_chk.sv
module ata_cmd_engine_chk
  import ata_eng_pkg::*;
#(
  parameter int WORDS       = 256,
  parameter int CAP_SECTORS = 4096,
  parameter int MAX_MULT    = 16,
  localparam int WIDX_W     = $clog2(WORDS),
  localparam int MULT_W     = $clog2(MAX_MULT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              ctl_blk,
  input logic              intrq,
  input logic              med_req,
  input logic              med_ack,
  input logic [27:0]       med_lba,
  input logic [WIDX_W-1:0] med_widx,
  input eng_state_t        state_q,
  input logic [7:0]        sc_q,
  input logic [7:0]        err_q,
  input logic              errf_q,
  input logic [MULT_W-1:0] mult_q
);
  logic in_drq, in_busy;
  assign in_drq  = (state_q == ST_XRD) || (state_q == ST_XWR);
  assign in_busy = (state_q != ST_IDLE) && !in_drq;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (med_req && !med_ack) |=> (med_req && $stable(med_lba) && $stable(med_widx))); // R4
  AST_NO_MEDIA_IN_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    in_drq |-> !med_req); // R5
  AST_INTR_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intrq) |-> !in_busy); // R6
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_busy && host_wr && !ctl_blk) |=> $stable(sc_q)); // R11
  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    errf_q |-> ((err_q == ERR_ABRT) || (err_q == ERR_IDNF))); // R2
  AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mult_q) <= MAX_MULT); // R7
  AST_MEDIA_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    med_req |-> (32'(med_lba) < CAP_SECTORS)); // R10
endmodule

bind ata_cmd_engine ata_cmd_engine_chk #(
  .WORDS(WORDS), .CAP_SECTORS(CAP_SECTORS), .MAX_MULT(MAX_MULT)
) u_chk (.*);

// File: tb/ata_cmd_engine_test.sv
module ata_cmd_engine_test;
  localparam int WORDS = 16;
  localparam int CAP   = 300;
  localparam int MAXM  = 4;
  localparam int LAT   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, ctl_blk = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic intrq, med_req, med_we;
  logic [27:0] med_lba;
  logic [3:0]  med_widx;
  logic [15:0] med_wdata;
  logic med_ack = 1'b0;
  logic [15:0] med_rdata = '0;

  int checks = 0, fails = 0, lat_cnt = 0;
  bit done = 0;
  logic [15:0] store [int];

  always #5 clk = ~clk;

  ata_cmd_engine #(.WORDS(WORDS), .CAP_SECTORS(CAP), .MAX_MULT(MAXM)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .ctl_blk(ctl_blk), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .intrq(intrq), .med_req(med_req), .med_we(med_we),
    .med_lba(med_lba), .med_widx(med_widx), .med_wdata(med_wdata),
    .med_ack(med_ack), .med_rdata(med_rdata)
  );

  function automatic logic [15:0] pat(int lba, int w);
    return 16'((lba * 37 + w * 5) ^ 16'hA5C3);
  endfunction
  function automatic logic [15:0] wpat(int lba, int w);
    return 16'(lba * 101 + w * 7 + 16'h1234);
  endfunction
  function automatic logic [15:0] media_word(int lba, int w);
    int k = lba * WORDS + w;
    return store.exists(k) ? store[k] : pat(lba, w);
  endfunction

  // behavioural medium: fixed latency, one-cycle acknowledge
  always @(negedge clk) begin
    if (!rst_n) begin med_ack = 1'b0; lat_cnt = 0; end
    else if (med_ack) begin med_ack = 1'b0; lat_cnt = 0; end
    else if (med_req) begin
      lat_cnt++;
      if (lat_cnt >= LAT) begin
        med_ack = 1'b1;
        if (med_we) store[int'(med_lba) * WORDS + int'(med_widx)] = med_wdata;
        else med_rdata = media_word(int'(med_lba), int'(med_widx));
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tf_wr(input logic [2:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; ctl_blk = 1'b0; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic ctl, output logic [15:0] d);
    host_addr = a; ctl_blk = ctl; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0; ctl_blk = 1'b0;
  endtask

  task automatic set_tf(input int lba, input int sc);
    tf_wr(3'd2, 16'(sc));
    tf_wr(3'd3, 16'(lba & 255));
    tf_wr(3'd4, 16'((lba >> 8) & 255));
    tf_wr(3'd5, 16'((lba >> 16) & 255));
    tf_wr(3'd6, 16'(8'hE0 | ((lba >> 24) & 15)));
  endtask

  task automatic poll(output logic [15:0] st);
    for (int i = 0; i < 40000; i++) begin
      rd(3'd7, 1'b1, st);
      if (st != 16'h0080) return;
    end
    chk("poll timeout", st, 16'h0050);
  endtask

  task automatic clr_intr(input string tag);
    logic [15:0] v;
    rd(3'd7, 1'b0, v);
    chk(tag, 16'(intrq), 16'h0000);
  endtask

  task automatic read_sectors(input int lba, input int n, input logic [7:0] cmd, input int blk);
    logic [15:0] v;
    set_tf(lba, n);
    tf_wr(3'd7, {8'h00, cmd});
    for (int s = 0; s < n; s++) begin
      poll(v);
      chk("R4 read status drq", v, 16'h0058);
      chk("R4 R6 read intrq at drq", 16'(intrq), 16'((s % blk) == 0));
      if (intrq) clr_intr("R12 status read clears intrq");
      for (int w = 0; w < WORDS; w++) begin
        rd(3'd0, 1'b0, v);
        chk("R4 read data word", v, media_word(lba + s, w));
      end
    end
    poll(v);
    chk("R4 read final status", v, 16'h0050);
    chk("R4 no interrupt at read end", 16'(intrq), 16'h0000);
    rd(3'd3, 1'b0, v);
    chk("R9 address after read", v, 16'((lba + n) & 255));
  endtask

  task automatic write_sectors(input int lba, input int n, input logic [7:0] cmd, input int blk);
    logic [15:0] v;
    set_tf(lba, n);
    tf_wr(3'd7, {8'h00, cmd});
    for (int s = 0; s < n; s++) begin
      poll(v);
      chk("R5 write status drq", v, 16'h0058);
      chk("R5 R6 write intrq at drq", 16'(intrq), 16'((s > 0) && ((s % blk) == 0)));
      if (intrq) clr_intr("R12 status read clears intrq");
      for (int w = 0; w < WORDS; w++) tf_wr(3'd0, wpat(lba + s, w));
      rd(3'd7, 1'b1, v);
      chk("R5 busy during commit", v, 16'h0080);
    end
    poll(v);
    chk("R5 write final status", v, 16'h0050);
    chk("R5 write end intrq", 16'(intrq), 16'h0001);
    clr_intr("R12 status read clears intrq");
    for (int s = 0; s < n; s++)
      for (int w = 0; w < WORDS; w++)
        chk("R5 medium holds written word", media_word(lba + s, w), wpat(lba + s, w));
  endtask

  task automatic simple_cmd(input int lba, input int sc, input logic [7:0] cmd,
                            input logic [15:0] exp_st, input logic [15:0] exp_err, input string tag);
    logic [15:0] v;
    set_tf(lba, sc);
    tf_wr(3'd7, {8'h00, cmd});
    poll(v);
    chk({tag, " status"}, v, exp_st);
    rd(3'd1, 1'b0, v);
    chk({tag, " error byte"}, v, exp_err);
    chk({tag, " intrq"}, 16'(intrq), 16'h0001);
    clr_intr("R12 status read clears intrq");
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd7, 1'b1, v);  chk("R1 reset status", v, 16'h0050);
    chk("R1 reset intrq", 16'(intrq), 16'h0000);
    rd(3'd1, 1'b0, v);  chk("R1 reset error", v, 16'h0000);

    simple_cmd(20, 3, 8'hC4, 16'h0051, 16'h0004, "R7 multiple before size");
    simple_cmd(20, 5, 8'hC6, 16'h0051, 16'h0004, "R7 size above max");
    simple_cmd(20, 2, 8'hC6, 16'h0050, 16'h0000, "R7 R13 size accepted");

    read_sectors(5, 2, 8'h20, 1);
    write_sectors(10, 2, 8'h30, 1);
    read_sectors(10, 2, 8'h21, 1);
    read_sectors(20, 3, 8'hC4, 2);
    write_sectors(30, 3, 8'hC5, 2);

    // R8 verify
    set_tf(40, 3);
    tf_wr(3'd7, 16'h0040);
    rd(3'd7, 1'b1, v);  chk("R8 verify busy", v, 16'h0080);
    poll(v);            chk("R8 verify never drq", v, 16'h0050);
    chk("R8 verify intrq", 16'(intrq), 16'h0001);
    rd(3'd7, 1'b1, v);
    chk("R12 control-block read keeps intrq", 16'(intrq), 16'h0001);
    clr_intr("R12 status read clears intrq");
    rd(3'd3, 1'b0, v);  chk("R9 address after verify", v, 16'd43);

    // R3 zero count gives 256 sectors
    simple_cmd(0, 0, 8'h41, 16'h0050, 16'h0000, "R3 zero count verify");
    rd(3'd3, 1'b0, v);  chk("R3 address low after 256", v, 16'h0000);
    rd(3'd4, 1'b0, v);  chk("R3 address mid after 256", v, 16'h0001);

    // R10 capacity crossing
    simple_cmd(CAP - 1, 2, 8'h40, 16'h0051, 16'h0010, "R10 verify past capacity");
    rd(3'd3, 1'b0, v);  chk("R10 address stops at limit", v, 16'(CAP & 255));
    simple_cmd(CAP, 1, 8'h70, 16'h0051, 16'h0010, "R10 seek out of range");
    simple_cmd(5, 1, 8'h7F, 16'h0050, 16'h0000, "R2 R13 seek in range");

    simple_cmd(5, 1, 8'hA5, 16'h0051, 16'h0004, "R2 unknown opcode");
    simple_cmd(5, 1, 8'h10, 16'h0050, 16'h0000, "R2 R13 recalibrate");
    simple_cmd(5, 1, 8'hE0, 16'h0050, 16'h0000, "R2 power command");

    // R11 writes ignored while busy
    set_tf(50, 2);
    tf_wr(3'd7, 16'h0040);
    tf_wr(3'd2, 16'd9);
    tf_wr(3'd7, 16'h0020);
    poll(v);            chk("R11 busy command ignored", v, 16'h0050);
    rd(3'd2, 1'b0, v);  chk("R11 count unchanged", v, 16'd2);
    rd(3'd3, 1'b0, v);  chk("R11 R9 address after verify", v, 16'd52);
    clr_intr("R12 status read clears intrq");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule